// File: doc/BRIEF.md
# Request and Reply Post Queues

This block holds the host-visible queues of a message-based storage controller. The host posts the addresses of request frames by writing a request offset. An internal consumer, which fetches and runs those requests, pops them through a simple valid/pop port. When a request completes, the consumer pushes a reply. A good completion carries the request's 31-bit message context. A failed one carries the address of an error frame taken from a pool of free reply frames. The host reads replies from one offset. It returns spent error frames to the pool by writing to that same offset.

Reply entries set a sticky reply-pending status bit. The host clears that bit by writing one to it. Together with an externally driven doorbell-pending level, and under a small mask register, the status bit drives one interrupt output. A read of the reply offset when no reply is waiting returns an all-ones value, so the host can tell that nothing is queued. A post to a full request queue is lost and sets a sticky overflow flag.

Top module: `msg_post_queues`

## Requirements
- R1: A host write to offset 0x40 appends the write data to the request queue. The consumer sees the oldest entry on `reqData` while `reqValid` is high, and `reqPop` removes that entry.
- R2: A host read of offset 0x44 returns the oldest reply entry and removes it. When the reply queue is empty, the read returns 0xFFFFFFFF and nothing changes.
- R3: A context reply is stored as {1'b0, rplContext[30:0]}. An address reply is stored as {1'b1, frame[31:1]}, where frame is the oldest free-frame address, and that free frame is consumed.
- R4: A host write to offset 0x44 adds the write data to the free-frame pool, which `freeFrame`/`freeValid` expose. The write is dropped when the pool is full.
- R5: Status register 0x30 reads bit 3 as reply-pending and bit 0 as the `dbPending` input, with all other bits zero. Bit 3 sets one cycle after the reply queue is non-empty and stays set until a write to 0x30 with bit 3 = 1 clears it. If entries remain, it sets again on the following cycle.
- R6: Mask register 0x34 resets to 0x00000009. Only bits 0, 3, 8 and 9 can be written, and the other bits always read zero.
- R7: `irqOut` is high exactly when (status bit 3 and not mask bit 3) or (status bit 0 and not mask bit 0).
- R8: `rplReady` is low when the reply queue is full. It is also low when `rplAddrReply` is high and the free-frame pool is empty. A push while `rplReady` is low has no effect.
- R9: A request write to a full request queue is dropped and leaves the queued entries unchanged. It sets `reqOverflow`, which stays high until reset.
- R10: A host reply read and a consumer reply push in the same cycle both take effect. So do a host free-frame write and an address-reply push in the same cycle. Reads of any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (a reply read pops) |
| hostAddr | input | ADDR_W | Host register byte offset |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid in the cycle of `hostRdEn` |
| dbPending | input | 1 | Doorbell-pending level from the doorbell logic |
| irqOut | output | 1 | Interrupt request |
| reqValid | output | 1 | Request queue holds an entry |
| reqData | output | 32 | Oldest request frame address |
| reqPop | input | 1 | Consumer removes the oldest request |
| reqOverflow | output | 1 | Sticky: a request post was lost |
| rplPush | input | 1 | Consumer pushes a reply |
| rplAddrReply | input | 1 | 1 = address (error) reply, 0 = context reply |
| rplContext | input | 31 | Message context for a context reply |
| rplReady | output | 1 | A reply push would be accepted this cycle |
| freeValid | output | 1 | Free-frame pool holds an entry |
| freeFrame | output | 32 | Free frame that the next address reply will use |

## Verification
There are two kinds of same-cycle collision. In the first, the host pops the reply queue while the consumer pushes a reply into it. In the second, the host returns a free frame while an address reply consumes one. The bench drives each pair in a single cycle, once with the reply queue empty and once with it holding an entry. The expected results are these: the read returns the old head, or the sentinel when the queue was empty; the pushed reply appears in order on the following reads; and the address reply is built from the frame that was oldest before the host's write.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int OFF_STATUS = 'h30;
  localparam int OFF_MASK   = 'h34;
  localparam int OFF_REQ    = 'h40;
  localparam int OFF_REPLY  = 'h44;
  localparam logic [31:0] MASK_WRITABLE = 32'h0000_0309;
  localparam logic [31:0] MASK_RESET    = 32'h0000_0009;
  localparam logic [31:0] EMPTY_READ    = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {RD_ZERO, RD_STATUS, RD_MASK, RD_REPLY} rdSel_e;

  typedef struct packed {
    logic   reqPush;
    logic   rplPop;
    logic   freePush;
    logic   stsClrRpl;
    logic   maskWr;
    rdSel_e rdSel;
  } mqStrobes_t;
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN) push |-> !full); // R8
  AST_FIFO_POP_DATA:  assert property (@(posedge clk) disable iff (!rstN) pop |-> !empty); // R2
endmodule

// File: rtl/mq_ctrl.sv
module mq_ctrl
  import mq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              wrBit3,
  output mqStrobes_t        st
);
  logic hitSts, hitMask, hitReq, hitRpl;

  assign hitSts  = (hostAddr == ADDR_W'(OFF_STATUS));
  assign hitMask = (hostAddr == ADDR_W'(OFF_MASK));
  assign hitReq  = (hostAddr == ADDR_W'(OFF_REQ));
  assign hitRpl  = (hostAddr == ADDR_W'(OFF_REPLY));

  always_comb begin
    st           = '0;
    st.rdSel     = RD_ZERO;
    st.reqPush   = hostWrEn & hitReq;
    st.freePush  = hostWrEn & hitRpl;
    st.maskWr    = hostWrEn & hitMask;
    st.stsClrRpl = hostWrEn & hitSts & wrBit3;
    st.rplPop    = hostRdEn & hitRpl;
    if (hostRdEn) begin
      if (hitSts)       st.rdSel = RD_STATUS;
      else if (hitMask) st.rdSel = RD_MASK;
      else if (hitRpl)  st.rdSel = RD_REPLY;
    end
  end

  AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.reqPush, st.freePush, st.maskWr, st.stsClrRpl})); // R1
endmodule

// File: rtl/mq_datapath.sv
module mq_datapath
  import mq_pkg::*;
#(
  parameter int REQ_DEPTH  = 4,
  parameter int RPL_DEPTH  = 4,
  parameter int FREE_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  mqStrobes_t  st,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  input  logic        dbPending,
  output logic        irqOut,
  output logic        reqValid,
  output logic [31:0] reqData,
  input  logic        reqPop,
  output logic        reqOverflow,
  input  logic        rplPush,
  input  logic        rplAddrReply,
  input  logic [30:0] rplContext,
  output logic        rplReady,
  output logic        freeValid,
  output logic [31:0] freeFrame
);
  logic        reqEmpty, reqFull, rplEmpty, rplFull, freeEmpty, freeFull;
  logic        reqPushOk, rplPushOk, rplPopOk, freePushOk, freePopOk;
  logic [31:0] rplHead, rplEntry;
  logic        rplStat;
  logic [31:0] maskReg;

  assign reqPushOk  = st.reqPush & ~reqFull;
  assign rplReady   = ~rplFull & (~rplAddrReply | ~freeEmpty);
  assign rplPushOk  = rplPush & rplReady;
  assign rplPopOk   = st.rplPop & ~rplEmpty;
  assign freePushOk = st.freePush & ~freeFull;
  assign freePopOk  = rplPushOk & rplAddrReply;
  assign rplEntry   = rplAddrReply ? {1'b1, freeFrame[31:1]} : {1'b0, rplContext};

  mq_fifo #(.WIDTH(32), .DEPTH(REQ_DEPTH)) uReq (
    .clk, .rstN, .push(reqPushOk), .pushData(hostWrData),
    .pop(reqPop & ~reqEmpty), .head(reqData), .empty(reqEmpty), .full(reqFull));

  mq_fifo #(.WIDTH(32), .DEPTH(RPL_DEPTH)) uRpl (
    .clk, .rstN, .push(rplPushOk), .pushData(rplEntry),
    .pop(rplPopOk), .head(rplHead), .empty(rplEmpty), .full(rplFull));

  mq_fifo #(.WIDTH(32), .DEPTH(FREE_DEPTH)) uFree (
    .clk, .rstN, .push(freePushOk), .pushData(hostWrData),
    .pop(freePopOk), .head(freeFrame), .empty(freeEmpty), .full(freeFull));

  assign reqValid  = ~reqEmpty;
  assign freeValid = ~freeEmpty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqOverflow <= 1'b0;
      rplStat     <= 1'b0;
      maskReg     <= MASK_RESET;
    end else begin
      if (st.reqPush && reqFull) reqOverflow <= 1'b1;
      if (st.stsClrRpl)          rplStat <= 1'b0;
      else if (!rplEmpty)        rplStat <= 1'b1;
      if (st.maskWr)             maskReg <= hostWrData & MASK_WRITABLE;
    end
  end

  always_comb begin
    unique case (st.rdSel)
      RD_STATUS: hostRdData = {28'b0, rplStat, 2'b00, dbPending};
      RD_MASK:   hostRdData = maskReg;
      RD_REPLY:  hostRdData = rplEmpty ? EMPTY_READ : rplHead;
      default:   hostRdData = '0;
    endcase
  end

  assign irqOut = (rplStat & ~maskReg[3]) | (dbPending & ~maskReg[0]);

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    reqOverflow |=> reqOverflow); // R9
  AST_FULL_POST_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (st.reqPush && reqFull && !reqPop) |=> reqFull); // R9
  AST_STATUS_REARM: assert property (@(posedge clk) disable iff (!rstN)
    (!rplStat && !rplEmpty && !st.stsClrRpl) |=> rplStat); // R5
  AST_MASK_RO_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg & ~MASK_WRITABLE) == 32'b0); // R6
  AST_EMPTY_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdSel == RD_REPLY && rplEmpty) |-> hostRdData == EMPTY_READ); // R2
  AST_ADDR_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    (rplAddrReply && !freeValid) |-> !rplReady); // R8
  AST_IRQ_FULLY_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg[0] && maskReg[3]) |-> !irqOut); // R7
endmodule

// File: rtl/msg_post_queues.sv
module msg_post_queues
  import mq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REQ_DEPTH  = 4,
  parameter int RPL_DEPTH  = 4,
  parameter int FREE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  input  logic              dbPending,
  output logic              irqOut,
  output logic              reqValid,
  output logic [31:0]       reqData,
  input  logic              reqPop,
  output logic              reqOverflow,
  input  logic              rplPush,
  input  logic              rplAddrReply,
  input  logic [30:0]       rplContext,
  output logic              rplReady,
  output logic              freeValid,
  output logic [31:0]       freeFrame
);
  mqStrobes_t st;

  mq_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk, .rstN, .hostWrEn, .hostRdEn, .hostAddr,
    .wrBit3(hostWrData[3]), .st);

  mq_datapath #(.REQ_DEPTH(REQ_DEPTH), .RPL_DEPTH(RPL_DEPTH), .FREE_DEPTH(FREE_DEPTH)) uDp (
    .clk, .rstN, .st, .hostWrData, .hostRdData, .dbPending, .irqOut,
    .reqValid, .reqData, .reqPop, .reqOverflow,
    .rplPush, .rplAddrReply, .rplContext, .rplReady, .freeValid, .freeFrame);
endmodule

// File: tb/tb_msg_post_queues.sv
module tb_msg_post_queues;
  localparam int RPL_D = 4, FREE_D = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostWrEn = 0, hostRdEn = 0;
  logic [7:0] hostAddr = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic dbPending = 0, irqOut;
  logic reqValid, reqPop = 0, reqOverflow;
  logic [31:0] reqData;
  logic rplPush = 0, rplAddrReply = 0, rplReady;
  logic [30:0] rplContext = '0;
  logic freeValid;
  logic [31:0] freeFrame;

  int vectors = 0, miscompares = 0;
  logic [31:0] expQ[$];
  logic [31:0] freeQ[$];

  always #4 clk = ~clk;

  msg_post_queues dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishCycle();
    @(posedge clk); #1;
    hostWrEn = 0; hostRdEn = 0; reqPop = 0; rplPush = 0; rplAddrReply = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic hostWrite(logic [7:0] a, logic [31:0] d);
    hostWrEn = 1; hostAddr = a; hostWrData = d;
    if (a == 8'h44 && freeQ.size() < FREE_D) freeQ.push_back(d);
    finishCycle();
  endtask

  task automatic hostReadCheck(string req, logic [7:0] a, logic [31:0] exp);
    hostRdEn = 1; hostAddr = a;
    @(negedge clk);
    check(req, hostRdData, exp);
    finishCycle();
  endtask

  // monitor side of the scoreboard: pops the expected reply and compares
  task automatic readReply(string req);
    logic [31:0] exp;
    exp = (expQ.size() == 0) ? 32'hFFFF_FFFF : expQ.pop_front();
    hostReadCheck(req, 8'h44, exp);
  endtask

  // driver side: predicts acceptance and entry, queues the expectation
  task automatic consumerPush(string req, logic addrFlag, logic [30:0] ctx);
    logic expReady;
    expReady = (expQ.size() < RPL_D) && (!addrFlag || freeQ.size() > 0);
    rplPush = 1; rplAddrReply = addrFlag; rplContext = ctx;
    @(negedge clk);
    check(req, {31'b0, rplReady}, {31'b0, expReady});
    if (expReady) begin
      if (addrFlag) expQ.push_back({1'b1, freeQ[0][31:1]});
      else          expQ.push_back({1'b0, ctx});
      if (addrFlag) void'(freeQ.pop_front());
    end
    finishCycle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    idle(1);

    // reset state
    hostReadCheck("R5 reset status", 8'h30, 32'h0);
    hostReadCheck("R6 reset mask", 8'h34, 32'h9);
    check("R7 reset irq", {31'b0, irqOut}, 32'h0);
    check("R1 reset reqValid", {31'b0, reqValid}, 32'h0);
    check("R9 reset overflow", {31'b0, reqOverflow}, 32'h0);
    readReply("R2 empty read sentinel");
    hostReadCheck("R10 unmapped read", 8'h48, 32'h0);
    hostReadCheck("R10 request offset read", 8'h40, 32'h0);

    // R1 request posting in order
    hostWrite(8'h40, 32'hA000_0010);
    hostWrite(8'h40, 32'hA000_0020);
    check("R1 valid", {31'b0, reqValid}, 32'h1);
    check("R1 head first", reqData, 32'hA000_0010);
    reqPop = 1; finishCycle();
    check("R1 head second", reqData, 32'hA000_0020);
    reqPop = 1; finishCycle();
    check("R1 drained", {31'b0, reqValid}, 32'h0);

    // R9 overflow on full request queue
    for (int i = 0; i < 5; i++) hostWrite(8'h40, 32'hB000_0000 + i);
    check("R9 overflow set", {31'b0, reqOverflow}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      check("R9 kept entry", reqData, 32'hB000_0000 + i);
      reqPop = 1; finishCycle();
    end
    check("R9 fifth dropped", {31'b0, reqValid}, 32'h0);
    check("R9 overflow sticky", {31'b0, reqOverflow}, 32'h1);

    // R3 context replies and R2 ordering
    consumerPush("R3 ctx push", 1'b0, 31'h0000_1234);
    consumerPush("R3 ctx push max", 1'b0, 31'h7FFF_FFFF);
    readReply("R3 ctx entry");
    readReply("R3 ctx entry max");
    readReply("R2 sentinel after drain");

    // R8 address reply needs a free frame; R4 free-frame pool
    consumerPush("R8 addr reply without frame", 1'b1, 31'h0);
    hostWrite(8'h44, 32'h0000_1000);
    hostWrite(8'h44, 32'h0000_2000);
    hostWrite(8'h44, 32'h0000_3000);
    check("R4 free head", freeFrame, 32'h0000_1000);
    consumerPush("R3 addr reply 1", 1'b1, 31'h0);
    consumerPush("R3 addr reply 2", 1'b1, 31'h0);
    check("R4 third frame dropped", {31'b0, freeValid}, 32'h0);
    consumerPush("R8 addr reply pool empty", 1'b1, 31'h0);
    readReply("R3 addr entry 1");
    readReply("R3 addr entry 2");

    // R8 reply queue full
    for (int i = 0; i < 5; i++) consumerPush("R8 fill reply queue", 1'b0, 31'h100 + i);
    for (int i = 0; i < 5; i++) readReply("R8 full drain");

    // R6 mask writes
    hostWrite(8'h34, 32'hFFFF_FFFF);
    hostReadCheck("R6 writable bits only", 8'h34, 32'h309);
    hostWrite(8'h34, 32'h0);
    hostReadCheck("R6 mask cleared", 8'h34, 32'h0);

    // R5 / R7 status and interrupt (status still set from earlier replies)
    hostWrite(8'h30, 32'h8);
    idle(1);
    hostReadCheck("R5 cleared when empty", 8'h30, 32'h0);
    check("R7 irq low", {31'b0, irqOut}, 32'h0);
    consumerPush("R5 push a", 1'b0, 31'h0AA);
    consumerPush("R5 push b", 1'b0, 31'h0BB);
    hostReadCheck("R5 set on pending", 8'h30, 32'h8);
    check("R7 irq from reply", {31'b0, irqOut}, 32'h1);
    hostWrite(8'h30, 32'h8);
    hostReadCheck("R5 cleared by W1C", 8'h30, 32'h0);
    hostReadCheck("R5 re-armed", 8'h30, 32'h8);
    hostWrite(8'h34, 32'h8);
    check("R7 reply masked", {31'b0, irqOut}, 32'h0);
    dbPending = 1; #1;
    check("R7 doorbell irq", {31'b0, irqOut}, 32'h1);
    hostReadCheck("R5 doorbell bit", 8'h30, 32'h9);
    hostWrite(8'h34, 32'h9);
    check("R7 doorbell masked", {31'b0, irqOut}, 32'h0);
    dbPending = 0;
    readReply("R2 pop a");
    readReply("R2 pop b");
    hostReadCheck("R5 sticky after empty", 8'h30, 32'h8);

    // R10 same-cycle pop and push, queue empty
    hostRdEn = 1; hostAddr = 8'h44; rplPush = 1; rplAddrReply = 0; rplContext = 31'h55;
    @(negedge clk);
    check("R10 empty pop with push", hostRdData, 32'hFFFF_FFFF);
    finishCycle();
    expQ.push_back(32'h55);
    // R10 same-cycle pop and push, one entry queued
    hostRdEn = 1; hostAddr = 8'h44; rplPush = 1; rplAddrReply = 0; rplContext = 31'h66;
    @(negedge clk);
    check("R10 pop old head", hostRdData, expQ.pop_front());
    finishCycle();
    expQ.push_back(32'h66);
    readReply("R10 pushed entry kept");
    readReply("R10 then empty");

    // R10 free-frame write with address reply in the same cycle
    hostWrite(8'h44, 32'h0000_4000);
    hostWrEn = 1; hostAddr = 8'h44; hostWrData = 32'h0000_6000;
    rplPush = 1; rplAddrReply = 1;
    @(negedge clk);
    check("R10 addr ready", {31'b0, rplReady}, 32'h1);
    finishCycle();
    void'(freeQ.pop_front());
    freeQ.push_back(32'h0000_6000);
    expQ.push_back(32'h8000_2000);
    check("R10 new frame at head", freeFrame, 32'h0000_6000);
    readReply("R10 addr reply used old frame");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule